// File: doc/BRIEF.md
# Gesture-Driven Photo Frame Selector

This block chooses which of several equal-sized pictures a display read engine shows. The pictures sit one above another in a single linear frame store. With the default settings there are three pictures of 800 pixels by 480 lines, so the store holds one 800x1440 picture, and picture k starts on line 480*k. A touch-gesture decoder flags each new report with a ready line and supplies an 8-bit gesture code. Horizontal swipe gestures step through the pictures, and the two pinch gestures raise or lower a zoom level.

A request is only recorded when it arrives. It takes effect at the next frame-start strobe from the display scan engine, so the picture and zoom level never change part-way through a frame; with the usual 60 Hz refresh, a request waits at most one frame. For the selected picture the block gives the read engine a first-line offset and a first-pixel address, and it gives the scaler a zoom level.

Top module: `gallery_view_sel`

## Requirements
- R1: A synchronous active-low reset sets the picture index, zoom level, line offset and pixel address all to 0.
- R2: The gesture code is sampled only in a cycle in which touch_rdy is high after being low in the previous cycle. A touch_rdy level that stays high, including one already high when reset is released, samples nothing further.
- R3: Code 0x1C advances the picture index by one, wrapping from 2 back to 0.
- R4: Code 0x14 moves the picture index back by one, wrapping from 0 to 2.
- R5: Code 0x48 raises the zoom level by one and saturates at 3. Code 0x49 lowers it by one and saturates at 0. Neither code changes the picture.
- R6: Every other code, including 0x00, 0x10 and 0x18, leaves the picture index and the zoom level unchanged.
- R7: line_base always equals index*480, and pix_base always equals index*384000.
- R8: The outputs change only on the clock edge at which frame_start is sampled high. A recorded request stays pending until that edge.
- R9: Any change of picture sets the zoom level to 0.
- R10: A newer ready edge before the frame strobe replaces the pending request, whatever its code. Exactly one request is applied per strobe, and the request is then consumed.
- R11: A ready edge in the same cycle as frame_start is applied at that strobe, in place of any older pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| touch_rdy | input | 1 | New-report flag from the gesture decoder; its rising edge qualifies gest_code |
| gest_code | input | 8 | Decoded gesture code |
| frame_start | input | 1 | One-cycle strobe at the start of each display frame |
| img_sel | output | 2 | Index of the picture currently shown |
| line_base | output | 11 | First line of the selected picture in the stacked store |
| pix_base | output | 21 | Linear address of the selected picture's first pixel |
| zoom_lvl | output | 2 | Current zoom level |

## Verification
A new gesture report and the frame strobe can arrive in the same cycle. The bench provokes this by first leaving one request pending and then raising touch_rdy together with frame_start. It judges the result by checking that only the newer request is visible after the strobe, and that a code with no effect cancels the older one. The other half of the interaction is covered by checking the outputs after every report and before every strobe, which confirms that nothing leaks through between frames.

// File: rtl/gallery_pkg.sv
// Shared types and gesture codes for the photo frame selector.
// Assumes the gesture decoder encodes gestures as the codes listed below.
package gallery_pkg;

    typedef enum logic [2:0] {
        REQ_NONE = 3'd0,
        REQ_NEXT = 3'd1,
        REQ_PREV = 3'd2,
        REQ_ZIN  = 3'd3,
        REQ_ZOUT = 3'd4
    } view_req_e;

    localparam logic [7:0] GC_SWIPE_RIGHT = 8'h1C;
    localparam logic [7:0] GC_SWIPE_LEFT  = 8'h14;
    localparam logic [7:0] GC_PINCH_OUT   = 8'h48;
    localparam logic [7:0] GC_PINCH_IN    = 8'h49;

    // Map a raw gesture code to a view request; unknown codes are no-ops.
    function automatic view_req_e decode_gesture(input logic [7:0] code);
        case (code)
            GC_SWIPE_RIGHT: decode_gesture = REQ_NEXT;
            GC_SWIPE_LEFT:  decode_gesture = REQ_PREV;
            GC_PINCH_OUT:   decode_gesture = REQ_ZIN;
            GC_PINCH_IN:    decode_gesture = REQ_ZOUT;
            default:        decode_gesture = REQ_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gallery_req_capture.sv
// Detects rising edges of the touch-ready flag, decodes the gesture code
// and holds a single pending request until the frame strobe consumes it.
// Assumes touch_rdy is already synchronous to clk. The edge detector
// resets to "high" so a level present at reset release is not an edge.
module gallery_req_capture
    import gallery_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      touch_rdy,
    input  logic [7:0] gest_code,
    input  logic      commit,
    output view_req_e req_eff
);

    logic      rdy_q;
    logic      rdy_edge;
    view_req_e req_new;
    view_req_e pend_q;

    assign rdy_edge = touch_rdy & ~rdy_q;
    assign req_new  = decode_gesture(gest_code);
    // A fresh edge in the commit cycle overrides the older pending request.
    assign req_eff  = rdy_edge ? req_new : pend_q;

    // Delay touch_rdy by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) rdy_q <= 1'b1;
        else        rdy_q <= touch_rdy;
    end

    // Keep the latest request; clear it when the frame strobe consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= REQ_NONE;
        else if (commit)   pend_q <= REQ_NONE;
        else if (rdy_edge) pend_q <= req_new;
    end

endmodule

// File: rtl/gallery_view_state.sv
// Holds the picture index and zoom level and applies a request on commit.
// Index wraps around the picture count; zoom saturates at both ends and
// returns to 0 whenever the picture changes.
module gallery_view_state
    import gallery_pkg::*;
#(
    parameter int NUM_IMG  = 3,
    parameter int ZOOM_MAX = 3,
    localparam int IDX_W   = (NUM_IMG > 1) ? $clog2(NUM_IMG) : 1,
    localparam int ZOOM_W  = (ZOOM_MAX > 0) ? $clog2(ZOOM_MAX + 1) : 1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  view_req_e         req,
    output logic [IDX_W-1:0]  idx_q,
    output logic [IDX_W-1:0]  idx_d,
    output logic [ZOOM_W-1:0] zoom_q
);

    localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(NUM_IMG - 1);
    localparam logic [ZOOM_W-1:0] ZOOM_TOP = ZOOM_W'(ZOOM_MAX);

    logic [ZOOM_W-1:0] zoom_d;

    // Work out the index and zoom that the pending request would produce.
    always_comb begin
        idx_d  = idx_q;
        zoom_d = zoom_q;
        case (req)
            REQ_NEXT: begin
                idx_d  = (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
                zoom_d = '0;
            end
            REQ_PREV: begin
                idx_d  = (idx_q == '0) ? IDX_LAST : idx_q - 1'b1;
                zoom_d = '0;
            end
            REQ_ZIN:  zoom_d = (zoom_q == ZOOM_TOP) ? zoom_q : zoom_q + 1'b1;
            REQ_ZOUT: zoom_d = (zoom_q == '0) ? zoom_q : zoom_q - 1'b1;
            default: ;
        endcase
    end

    // Commit the new view only at the frame strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            zoom_q <= '0;
        end else if (commit) begin
            idx_q  <= idx_d;
            zoom_q <= zoom_d;
        end
    end

endmodule

// File: rtl/gallery_addr_gen.sv
// Registers the first line and first pixel address of the picture that is
// being committed, so they update on the same edge as the index.
// Assumes pictures are stacked vertically with no padding between them.
module gallery_addr_gen #(
    parameter int IDX_W  = 2,
    parameter int LINE_W = 11,
    parameter int ADDR_W = 21,
    parameter int IMG_W  = 800,
    parameter int IMG_H  = 480
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [IDX_W-1:0]  idx_d,
    output logic [LINE_W-1:0] line_q,
    output logic [ADDR_W-1:0] addr_q
);

    localparam logic [LINE_W-1:0] LINE_STEP = LINE_W'(IMG_H);
    localparam logic [ADDR_W-1:0] PIX_STEP  = ADDR_W'(IMG_W * IMG_H);

    logic [LINE_W-1:0] line_d;
    logic [ADDR_W-1:0] addr_d;

    // Scale the index by constant picture sizes.
    always_comb begin
        line_d = LINE_W'(idx_d) * LINE_STEP;
        addr_d = ADDR_W'(idx_d) * PIX_STEP;
    end

    // Hold the base values between frame strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            addr_q <= '0;
        end else if (load) begin
            line_q <= line_d;
            addr_q <= addr_d;
        end
    end

endmodule

// File: rtl/gallery_view_sel.sv
// Top of the photo frame selector: captures gesture reports, applies the
// latest one at each frame strobe and publishes the picture base and zoom.
// Assumes frame_start is a single-cycle strobe in the clk domain.
module gallery_view_sel
    import gallery_pkg::*;
#(
    parameter int NUM_IMG  = 3,
    parameter int IMG_W    = 800,
    parameter int IMG_H    = 480,
    parameter int ZOOM_MAX = 3,
    localparam int IDX_W   = (NUM_IMG > 1) ? $clog2(NUM_IMG) : 1,
    localparam int ZOOM_W  = (ZOOM_MAX > 0) ? $clog2(ZOOM_MAX + 1) : 1,
    localparam int LINE_W  = $clog2(NUM_IMG * IMG_H),
    localparam int ADDR_W  = $clog2(NUM_IMG * IMG_W * IMG_H)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              touch_rdy,
    input  logic [7:0]        gest_code,
    input  logic              frame_start,
    output logic [IDX_W-1:0]  img_sel,
    output logic [LINE_W-1:0] line_base,
    output logic [ADDR_W-1:0] pix_base,
    output logic [ZOOM_W-1:0] zoom_lvl
);

    view_req_e        req_eff;
    logic [IDX_W-1:0] idx_next;

    gallery_req_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_rdy (touch_rdy),
        .gest_code (gest_code),
        .commit    (frame_start),
        .req_eff   (req_eff)
    );

    gallery_view_state #(
        .NUM_IMG  (NUM_IMG),
        .ZOOM_MAX (ZOOM_MAX)
    ) u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (frame_start),
        .req    (req_eff),
        .idx_q  (img_sel),
        .idx_d  (idx_next),
        .zoom_q (zoom_lvl)
    );

    gallery_addr_gen #(
        .IDX_W  (IDX_W),
        .LINE_W (LINE_W),
        .ADDR_W (ADDR_W),
        .IMG_W  (IMG_W),
        .IMG_H  (IMG_H)
    ) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (frame_start),
        .idx_d  (idx_next),
        .line_q (line_base),
        .addr_q (pix_base)
    );

endmodule

// File: rtl/gallery_view_sel_chk.sv
// Assertion checker for gallery_view_sel, attached by bind below.
module gallery_view_sel_chk #(
    parameter int NUM_IMG  = 3,
    parameter int IMG_W    = 800,
    parameter int IMG_H    = 480,
    parameter int ZOOM_MAX = 3,
    parameter int IDX_W    = 2,
    parameter int ZOOM_W   = 2,
    parameter int LINE_W   = 11,
    parameter int ADDR_W   = 21
)(
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic [IDX_W-1:0]  img_sel,
    input logic [LINE_W-1:0] line_base,
    input logic [ADDR_W-1:0] pix_base,
    input logic [ZOOM_W-1:0] zoom_lvl
);

    logic in_rst_q;

    // Remember that the previous edge saw reset asserted.
    always_ff @(posedge clk) in_rst_q <= !rst_n;

    // Outputs must be cleared one edge after reset was sampled low.
    always_ff @(posedge clk) begin
        if (in_rst_q === 1'b1)
            AST_RESET_CLEAR: assert (img_sel == '0 && zoom_lvl == '0 &&
                                     line_base == '0 && pix_base == '0); // R1
    end

    AST_HOLD_BETWEEN_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(img_sel) && $stable(zoom_lvl) &&
                          $stable(line_base) && $stable(pix_base))); // R8

    AST_BASE_MATCHES_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(line_base) == int'(img_sel) * IMG_H) &&
        (int'(pix_base) == int'(img_sel) * IMG_H * IMG_W)); // R7

    AST_INDEX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(img_sel) < NUM_IMG); // R3

    AST_ZOOM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(zoom_lvl) <= ZOOM_MAX); // R5

    AST_ZOOM_CLEARED_ON_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(img_sel) |-> zoom_lvl == '0); // R9

    AST_NEIGHBOUR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(img_sel) |->
            (int'(img_sel) == (int'($past(img_sel)) + 1) % NUM_IMG) ||
            (int'($past(img_sel)) == (int'(img_sel) + 1) % NUM_IMG)); // R4

    AST_ZOOM_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(img_sel) && !$stable(zoom_lvl)) |->
            (int'(zoom_lvl) == int'($past(zoom_lvl)) + 1) ||
            (int'(zoom_lvl) + 1 == int'($past(zoom_lvl)))); // R5

endmodule

bind gallery_view_sel gallery_view_sel_chk #(
    .NUM_IMG  (NUM_IMG),
    .IMG_W    (IMG_W),
    .IMG_H    (IMG_H),
    .ZOOM_MAX (ZOOM_MAX),
    .IDX_W    (IDX_W),
    .ZOOM_W   (ZOOM_W),
    .LINE_W   (LINE_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .img_sel     (img_sel),
    .line_base   (line_base),
    .pix_base    (pix_base),
    .zoom_lvl    (zoom_lvl)
);

// File: tb/gallery_view_sel_tb.sv
// Self-checking bench: sweeps every gesture code repeatedly, plus directed
// cases for edges, saturation, replacement and same-cycle arrival.
module gallery_view_sel_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        touch_rdy = 1'b0;
    logic [7:0]  gest_code = '0;
    logic        frame_start = 1'b0;
    logic [1:0]  img_sel;
    logic [10:0] line_base;
    logic [20:0] pix_base;
    logic [1:0]  zoom_lvl;

    int vecs = 0;
    int errs = 0;
    int m_idx = 0;
    int m_zoom = 0;

    always #4 clk = ~clk;

    gallery_view_sel u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .touch_rdy   (touch_rdy),
        .gest_code   (gest_code),
        .frame_start (frame_start),
        .img_sel     (img_sel),
        .line_base   (line_base),
        .pix_base    (pix_base),
        .zoom_lvl    (zoom_lvl)
    );

    task automatic check_all(input string rq);
        int e_line;
        int e_addr;
        e_line = m_idx * 480;
        e_addr = m_idx * 384000;
        vecs++;
        if (int'(img_sel) != m_idx || int'(zoom_lvl) != m_zoom ||
            int'(line_base) != e_line || int'(pix_base) != e_addr) begin
            errs++;
            $display("FAIL %s: got sel=%0d zoom=%0d line=%0d addr=%0d, expected sel=%0d zoom=%0d line=%0d addr=%0d",
                     rq, img_sel, zoom_lvl, line_base, pix_base, m_idx, m_zoom, e_line, e_addr);
        end
    endtask

    function automatic void model_apply(input logic [7:0] c);
        case (c)
            8'h1C: begin m_idx = (m_idx + 1) % 3; m_zoom = 0; end
            8'h14: begin m_idx = (m_idx + 2) % 3; m_zoom = 0; end
            8'h48: if (m_zoom < 3) m_zoom++;
            8'h49: if (m_zoom > 0) m_zoom--;
            default: ;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] c);
        case (c)
            8'h1C:        tag_of = "R3/R9/R7";
            8'h14:        tag_of = "R4/R9/R7";
            8'h48, 8'h49: tag_of = "R5";
            default:      tag_of = "R6";
        endcase
    endfunction

    task automatic pulse_ready(input logic [7:0] c);
        @(negedge clk) touch_rdy = 1'b1; gest_code = c;
        @(negedge clk) touch_rdy = 1'b0;
    endtask

    task automatic pulse_frame();
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state, with ready already high across the release (R2).
        touch_rdy = 1'b1;
        gest_code = 8'h1C;
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        pulse_frame();
        check_all("R2");
        @(negedge clk) touch_rdy = 1'b0;

        // Full code sweep, checking before (R8) and after each strobe.
        for (int rep = 0; rep < 12; rep++) begin
            for (int c = 0; c < 256; c++) begin
                pulse_ready(8'(c));
                check_all("R8");
                pulse_frame();
                model_apply(8'(c));
                check_all(tag_of(8'(c)));
            end
        end

        // Forward and backward walks through every picture (R3, R4).
        for (int k = 0; k < 4; k++) begin
            pulse_ready(8'h1C); pulse_frame(); model_apply(8'h1C); check_all("R3");
        end
        for (int k = 0; k < 4; k++) begin
            pulse_ready(8'h14); pulse_frame(); model_apply(8'h14); check_all("R4");
        end

        // Zoom saturation at both ends (R5), then a switch clears it (R9).
        for (int k = 0; k < 5; k++) begin
            pulse_ready(8'h48); pulse_frame(); model_apply(8'h48); check_all("R5");
        end
        for (int k = 0; k < 5; k++) begin
            pulse_ready(8'h49); pulse_frame(); model_apply(8'h49); check_all("R5");
        end
        pulse_ready(8'h48); pulse_frame(); model_apply(8'h48);
        pulse_ready(8'h1C); pulse_frame(); model_apply(8'h1C); check_all("R9");

        // A level held high samples only once (R2).
        @(negedge clk) touch_rdy = 1'b1; gest_code = 8'h1C;
        pulse_frame(); model_apply(8'h1C); check_all("R2");
        @(negedge clk) gest_code = 8'h14;
        pulse_frame(); check_all("R2");
        @(negedge clk) touch_rdy = 1'b0;

        // Later edge replaces earlier; nothing queued (R10).
        pulse_ready(8'h1C); pulse_ready(8'h48);
        check_all("R10");
        pulse_frame(); model_apply(8'h48); check_all("R10");
        pulse_frame(); check_all("R10");
        pulse_ready(8'h1C); pulse_ready(8'h00);
        pulse_frame(); check_all("R10");

        // Edge in the strobe cycle wins over the pending one (R11).
        pulse_ready(8'h14);
        @(negedge clk) touch_rdy = 1'b1; gest_code = 8'h1C; frame_start = 1'b1;
        @(negedge clk) touch_rdy = 1'b0; frame_start = 1'b0;
        model_apply(8'h1C); check_all("R11");
        pulse_ready(8'h48);
        @(negedge clk) touch_rdy = 1'b1; gest_code = 8'h10; frame_start = 1'b1;
        @(negedge clk) touch_rdy = 1'b0; frame_start = 1'b0;
        check_all("R11");
        pulse_frame(); check_all("R11");

        // Reset from a non-zero state (R1).
        pulse_ready(8'h1C); pulse_frame(); model_apply(8'h1C);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        m_idx = 0; m_zoom = 0;
        check_all("R1");
        @(negedge clk) rst_n = 1'b1;

        finish_run();
    end

endmodule